// File: doc/BRIEF.md
# Paged Microsequencer With Late Branch

This block works out the address of the next microinstruction. Each microword carries an 8-bit sequencing field. Its two top bits choose the kind of successor, and the remaining bits give a target inside the current 64-word page, a condition selector, or a special operation. Because the control store is split into pages, only a few address bits are stored per word. The page of the current PC provides the upper address bits.

A conditional branch picks one of eight condition inputs and ORs it into bit 0 of an even in-page target. The assembler therefore places the not-taken target at an even address and the taken target directly above it. The block also holds one subroutine link register per task. Calls, far calls and returns load that register with the current PC plus one, which lets two routines hand control back and forth as coroutines. A bus write can load the link with a computed address, and a later link jump goes to that address. Other special operations take the successor from the instruction fetch unit (end of macroinstruction), dispatch 8 or 256 ways on bus bits, or jump to the start of a far page.

When the hold input is high, the current word turns into a no-op that jumps to itself. The next address is then the current PC and no link register changes.

Top module: `useq_next_addr`

## Requirements
- R1: After reset, every task's link register reads as address 0.
- R2: A field of the form 00oooooo gives next = {page of current PC, oooooo}. Page = cur_pc[11:6].
- R3: A field of the form 01oooooo goes to the same in-page target as R2 and loads the current task's link with cur_pc+1, wrapping 0xFFF to 0x000.
- R4: A field of the form 10sssttt gives next = {page, ttt, 3'b000} OR cond_vec[sss]. The false target is therefore even, and the true target is the odd address above it.
- R5: A field of the form 11xxx000 (return) gives next = the task's link, and loads that link with cur_pc+1.
- R6: A field of the form 11xxx001 gives next = ifu_addr.
- R7: A field of the form 11xxx010 (8-way dispatch) gives next = {page, 3'b111, bus_val[2:0]}.
- R8: A field of the form 11xxx011 (256-way dispatch) gives next = {cur_pc[11:8], bus_val[7:0]}.
- R9: A field of the form 11xxx100 gives next = {far_page, 6'b0}. The form 11xxx101 gives the same address and also loads the link with cur_pc+1.
- R10: The form 11xxx110 gives next = the task's link and leaves the link unchanged. The form 11xxx111 gives next = cur_pc.
- R11: While hold is high, next = cur_pc whatever the field is, and no link register changes, even when link_we is high.
- R12: When link_we is high, hold is low and the field does not load the link (R3, R5, R9), the current task's link takes bus_val.
- R13: Each task has its own link register. A load affects only the register of the task on task_id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_id | input | 4 | Task executing this cycle; selects the link register |
| cur_pc | input | 12 | Address of the current microinstruction |
| nctl | input | 8 | Sequencing field of the current microinstruction |
| cond_vec | input | 8 | Branch condition inputs |
| far_page | input | 6 | Page number for far jump and far call |
| bus_val | input | 12 | Bus value: dispatch selector or link load data |
| ifu_addr | input | 12 | Successor supplied by the instruction fetch unit |
| hold | input | 1 | Turns the current word into a jump-to-self no-op |
| link_we | input | 1 | Load the task's link from bus_val |
| nxt_pc | output | 12 | Next microinstruction address |

## Verification
The assertions check the purely combinational rules on every cycle: held words return to themselves, in-page gotos and branches stay in the current page with the branch bit equal to the selected condition, the dispatches and the fetch-unit successor take their bus values, and a return in the cycle after a call by the same task yields the caller's PC plus one. Some effects only the bench scenarios can show, because they are state read back through later link jumps: the link contents left after held cycles, bus loads that collide with calls, per-task isolation, and wraparound of PC plus one.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int unsigned INPAGE_W = 6;
  localparam int unsigned NCTL_W   = 8;
  localparam int unsigned NCOND    = 8;

  typedef enum logic [1:0] {
    KIND_GOTO    = 2'b00,
    KIND_CALL    = 2'b01,
    KIND_BRANCH  = 2'b10,
    KIND_SPECIAL = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    SP_RETURN    = 3'd0,
    SP_IFU       = 3'd1,
    SP_DISP8     = 3'd2,
    SP_DISP256   = 3'd3,
    SP_FAR_JUMP  = 3'd4,
    SP_FAR_CALL  = 3'd5,
    SP_LINK_JUMP = 3'd6,
    SP_SELF      = 3'd7
  } special_e;

  typedef enum logic [2:0] {
    SRC_INPAGE,
    SRC_BRANCH,
    SRC_LINK,
    SRC_IFU,
    SRC_DISP8,
    SRC_DISP256,
    SRC_FAR,
    SRC_SELF
  } src_e;

  typedef struct packed {
    src_e src;
    logic link_from_pc;
  } seq_ctl_t;

endpackage

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  logic [1:0] kind_bits,
  input  logic [2:0] op_bits,
  input  logic       hold,
  output seq_ctl_t   ctl
);

  always_comb begin
    ctl.src          = SRC_SELF;
    ctl.link_from_pc = 1'b0;
    if (!hold) begin
      unique case (kind_e'(kind_bits))
        KIND_GOTO:   ctl.src = SRC_INPAGE;
        KIND_CALL: begin
          ctl.src          = SRC_INPAGE;
          ctl.link_from_pc = 1'b1;
        end
        KIND_BRANCH: ctl.src = SRC_BRANCH;
        KIND_SPECIAL: begin
          unique case (special_e'(op_bits))
            SP_RETURN: begin
              ctl.src          = SRC_LINK;
              ctl.link_from_pc = 1'b1;
            end
            SP_IFU:       ctl.src = SRC_IFU;
            SP_DISP8:     ctl.src = SRC_DISP8;
            SP_DISP256:   ctl.src = SRC_DISP256;
            SP_FAR_JUMP:  ctl.src = SRC_FAR;
            SP_FAR_CALL: begin
              ctl.src          = SRC_FAR;
              ctl.link_from_pc = 1'b1;
            end
            SP_LINK_JUMP: ctl.src = SRC_LINK;
            SP_SELF:      ctl.src = SRC_SELF;
            default:      ctl.src = SRC_SELF;
          endcase
        end
        default: ctl.src = SRC_SELF;
      endcase
    end
  end

endmodule

// File: rtl/useq_link_file.sv
module useq_link_file #(
  parameter int unsigned AW    = 12,
  parameter int unsigned NTASK = 16,
  localparam int unsigned TW   = $clog2(NTASK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] sel_task,
  input  logic          wr_pc,
  input  logic          wr_bus,
  input  logic [AW-1:0] pc_inc,
  input  logic [AW-1:0] bus_val,
  output logic [AW-1:0] link_rd
);

  logic [AW-1:0] link_q [NTASK];
  logic [AW-1:0] wr_val;

  always_comb begin
    wr_val = wr_pc ? pc_inc : bus_val;
  end

  for (genvar t = 0; t < NTASK; t++) begin : g_task
    logic en_t;
    always_comb begin
      en_t = (wr_pc | wr_bus) && (sel_task == TW'(t));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        link_q[t] <= '0;
      end else if (en_t) begin
        link_q[t] <= wr_val;
      end
    end
  end

  always_comb begin
    link_rd = link_q[sel_task];
  end

endmodule

// File: rtl/useq_addr_mux.sv
module useq_addr_mux
  import useq_pkg::*;
#(
  parameter int unsigned AW = 12,
  localparam int unsigned PGW = AW - INPAGE_W
) (
  input  seq_ctl_t         ctl,
  input  logic [AW-1:0]    cur_pc,
  input  logic [7:0]       nctl,
  input  logic [NCOND-1:0] cond_vec,
  input  logic [PGW-1:0]   far_page,
  input  logic [AW-1:0]    bus_val,
  input  logic [AW-1:0]    ifu_addr,
  input  logic [AW-1:0]    link_rd,
  output logic [AW-1:0]    nxt_pc
);

  logic [PGW-1:0] page;
  logic           late_bit;

  always_comb begin
    page     = cur_pc[AW-1:INPAGE_W];
    late_bit = cond_vec[nctl[5:3]];
    unique case (ctl.src)
      SRC_INPAGE:  nxt_pc = {page, nctl[INPAGE_W-1:0]};
      SRC_BRANCH:  nxt_pc = {page, nctl[2:0], 2'b00, late_bit};
      SRC_LINK:    nxt_pc = link_rd;
      SRC_IFU:     nxt_pc = ifu_addr;
      SRC_DISP8:   nxt_pc = {page, 3'b111, bus_val[2:0]};
      SRC_DISP256: nxt_pc = {cur_pc[AW-1:8], bus_val[7:0]};
      SRC_FAR:     nxt_pc = {far_page, {INPAGE_W{1'b0}}};
      default:     nxt_pc = cur_pc;
    endcase
  end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int unsigned AW    = 12,
  parameter int unsigned NTASK = 16,
  localparam int unsigned TW   = $clog2(NTASK),
  localparam int unsigned PGW  = AW - INPAGE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    task_id,
  input  logic [AW-1:0]    cur_pc,
  input  logic [7:0]       nctl,
  input  logic [NCOND-1:0] cond_vec,
  input  logic [PGW-1:0]   far_page,
  input  logic [AW-1:0]    bus_val,
  input  logic [AW-1:0]    ifu_addr,
  input  logic             hold,
  input  logic             link_we,
  output logic [AW-1:0]    nxt_pc
);

  seq_ctl_t      ctl;
  logic [AW-1:0] link_rd;
  logic [AW-1:0] pc_inc;
  logic          wr_bus;

  always_comb begin
    pc_inc = cur_pc + AW'(1);
    wr_bus = link_we & ~hold & ~ctl.link_from_pc;
  end

  useq_decode i_decode (
    .kind_bits (nctl[7:6]),
    .op_bits   (nctl[2:0]),
    .hold      (hold),
    .ctl       (ctl)
  );

  useq_link_file #(.AW(AW), .NTASK(NTASK)) i_links (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_task (task_id),
    .wr_pc    (ctl.link_from_pc),
    .wr_bus   (wr_bus),
    .pc_inc   (pc_inc),
    .bus_val  (bus_val),
    .link_rd  (link_rd)
  );

  useq_addr_mux #(.AW(AW)) i_mux (
    .ctl      (ctl),
    .cur_pc   (cur_pc),
    .nctl     (nctl),
    .cond_vec (cond_vec),
    .far_page (far_page),
    .bus_val  (bus_val),
    .ifu_addr (ifu_addr),
    .link_rd  (link_rd),
    .nxt_pc   (nxt_pc)
  );

endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
  parameter int unsigned AW    = 12,
  parameter int unsigned NTASK = 16,
  localparam int unsigned TW   = $clog2(NTASK),
  localparam int unsigned PGW  = AW - 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] task_id,
  input logic [AW-1:0] cur_pc,
  input logic [7:0]    nctl,
  input logic [7:0]    cond_vec,
  input logic [AW-1:0] bus_val,
  input logic [AW-1:0] ifu_addr,
  input logic          hold,
  input logic [AW-1:0] nxt_pc
);

  logic loads_link;
  logic is_return;
  always_comb begin
    loads_link = !hold && ((nctl[7:6] == 2'b01) ||
                 (nctl[7:6] == 2'b11 && (nctl[2:0] == 3'd0 || nctl[2:0] == 3'd5)));
    is_return  = !hold && nctl[7:6] == 2'b11 && nctl[2:0] == 3'd0;
  end

  assert_hold_self_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> nxt_pc == cur_pc);

  assert_goto_inpage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && nctl[7:6] == 2'b00) |-> nxt_pc == {cur_pc[AW-1:6], nctl[5:0]});

  assert_branch_late_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && nctl[7:6] == 2'b10) |->
      (nxt_pc[0] == cond_vec[nctl[5:3]] && nxt_pc[AW-1:6] == cur_pc[AW-1:6]));

  assert_ifu_successor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && nctl[7:6] == 2'b11 && nctl[2:0] == 3'd1) |-> nxt_pc == ifu_addr);

  assert_disp8_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && nctl[7:6] == 2'b11 && nctl[2:0] == 3'd2) |->
      nxt_pc == {cur_pc[AW-1:6], 3'b111, bus_val[2:0]});

  assert_disp256_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && nctl[7:6] == 2'b11 && nctl[2:0] == 3'd3) |->
      nxt_pc == {cur_pc[AW-1:8], bus_val[7:0]});

  assert_return_after_call_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loads_link |=> ((is_return && task_id == $past(task_id)) ->
      nxt_pc == $past(cur_pc) + AW'(1)));

endmodule

bind useq_next_addr useq_next_addr_chk #(.AW(AW), .NTASK(NTASK)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .task_id  (task_id),
  .cur_pc   (cur_pc),
  .nctl     (nctl),
  .cond_vec (cond_vec),
  .bus_val  (bus_val),
  .ifu_addr (ifu_addr),
  .hold     (hold),
  .nxt_pc   (nxt_pc)
);

// File: tb/test_useq_next_addr.sv
module test_useq_next_addr;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  task_id;
  logic [11:0] cur_pc;
  logic [7:0]  nctl;
  logic [7:0]  cond_vec;
  logic [5:0]  far_page;
  logic [11:0] bus_val;
  logic [11:0] ifu_addr;
  logic        hold;
  logic        link_we;
  logic [11:0] nxt_pc;

  int checks = 0;
  int errors = 0;
  int mlink [16];

  always #5 clk = ~clk;

  useq_next_addr i_useq_next_addr (
    .clk(clk), .rst_n(rst_n), .task_id(task_id), .cur_pc(cur_pc),
    .nctl(nctl), .cond_vec(cond_vec), .far_page(far_page),
    .bus_val(bus_val), .ifu_addr(ifu_addr), .hold(hold),
    .link_we(link_we), .nxt_pc(nxt_pc)
  );

  function automatic int expect_next();
    int page = int'(cur_pc) / 64;
    int op   = int'(nctl) % 8;
    if (hold) return int'(cur_pc);
    case (int'(nctl) / 64)
      0, 1: return page * 64 + int'(nctl) % 64;
      2:    return page * 64 + op * 8 + int'(cond_vec[(int'(nctl) / 8) % 8]);
      default: begin
        case (op)
          0, 6:    return mlink[task_id];
          1:       return int'(ifu_addr);
          2:       return page * 64 + 56 + int'(bus_val) % 8;
          3:       return (int'(cur_pc) / 256) * 256 + int'(bus_val) % 256;
          4, 5:    return int'(far_page) * 64;
          default: return int'(cur_pc);
        endcase
      end
    endcase
  endfunction

  function automatic bit field_loads_link();
    int op = int'(nctl) % 8;
    int k  = int'(nctl) / 64;
    return (k == 1) || (k == 3 && (op == 0 || op == 5));
  endfunction

  task automatic step(input string req);
    int exp_v;
    #1;
    exp_v = expect_next();
    checks++;
    if (int'(nxt_pc) != exp_v) begin
      errors++;
      $display("FAIL %s: nctl=%h pc=%h task=%0d hold=%b actual=%h expected=%h",
               req, nctl, cur_pc, task_id, hold, nxt_pc, exp_v[11:0]);
    end
    if (!hold) begin
      if (field_loads_link()) mlink[task_id] = (int'(cur_pc) + 1) % 4096;
      else if (link_we)       mlink[task_id] = int'(bus_val);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    hold = 0; link_we = 0; cond_vec = 0; bus_val = 0; ifu_addr = 0; far_page = 0;
    task_id = 0; cur_pc = 0; nctl = 8'h3F;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < 16; t++) mlink[t] = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: link jump on every task returns the reset value
    for (int t = 0; t < 16; t++) begin
      task_id = 4'(t); cur_pc = 12'h123; nctl = 8'hC6;
      step("R1");
    end

    // R2: in-page goto over all offsets and several pages
    for (int p = 0; p < 4; p++)
      for (int o = 0; o < 64; o++) begin
        cur_pc = 12'(p * 1000 + 7); nctl = 8'(o);
        step("R2");
      end

    // R4: every selector, target and condition pattern
    for (int s = 0; s < 8; s++)
      for (int g = 0; g < 8; g++)
        for (int pat = 0; pat < 4; pat++) begin
          cur_pc = 12'(s * 300 + g);
          nctl = 8'(128 + s * 8 + g);
          case (pat)
            0: cond_vec = 8'h00;
            1: cond_vec = 8'(1 << s);
            2: cond_vec = ~8'(1 << s);
            default: cond_vec = 8'hFF;
          endcase
          step("R4");
        end
    cond_vec = 0;

    // R3, R13: call on every task, then R5 return on every task
    for (int t = 0; t < 16; t++) begin
      task_id = 4'(t); cur_pc = 12'(t * 211 + 5); nctl = 8'(64 + t);
      step("R3");
    end
    for (int t = 0; t < 16; t++) begin
      task_id = 4'(t); cur_pc = 12'(t * 17 + 900); nctl = 8'hC0;
      step("R5");
    end
    for (int t = 0; t < 16; t++) begin
      task_id = 4'(t); cur_pc = 12'h001; nctl = 8'hF6;
      step("R13");
    end

    // R3: PC+1 wraps around
    task_id = 4'd3; cur_pc = 12'hFFF; nctl = 8'h45; step("R3");
    nctl = 8'hC6; cur_pc = 12'h010; step("R3");

    // R6: fetch-unit successor
    for (int i = 0; i < 8; i++) begin
      ifu_addr = 12'(i * 511 + 3); cur_pc = 12'(i * 99); nctl = 8'(192 + i * 8 + 1);
      step("R6");
    end

    // R7: 8-way dispatch, upper bus bits ignored
    for (int i = 0; i < 32; i++) begin
      bus_val = 12'(i * 137); cur_pc = 12'(i * 129); nctl = 8'hC2;
      step("R7");
    end

    // R8: 256-way dispatch over every selector
    for (int i = 0; i < 256; i++) begin
      bus_val = 12'(i + 12'hA00); cur_pc = 12'h5A3; nctl = 8'hDB;
      step("R8");
    end

    // R9: far jump on every page, far call then link readback
    for (int f = 0; f < 64; f++) begin
      far_page = 6'(f); cur_pc = 12'(f * 7); nctl = 8'hC4;
      step("R9");
    end
    task_id = 4'd9; far_page = 6'd33; cur_pc = 12'h7E2; nctl = 8'hC5; step("R9");
    nctl = 8'hC6; cur_pc = 12'h000; step("R9");

    // R10: link jump leaves link alone; self loop
    nctl = 8'hC6; cur_pc = 12'h444; step("R10");
    nctl = 8'hFF; cur_pc = 12'hABC; step("R10");

    // R11: hold over all kinds with link_we, then link unchanged
    task_id = 4'd9;
    for (int k = 0; k < 16; k++) begin
      hold = 1; link_we = 1; bus_val = 12'(k * 255);
      cur_pc = 12'(k * 260 + 1); nctl = 8'(k * 16 + k % 8);
      cond_vec = 8'hFF;
      step("R11");
    end
    hold = 0; link_we = 0; nctl = 8'hC6; step("R11");

    // R12: bus load with goto, then readback; collision with call
    task_id = 4'd12; link_we = 1; bus_val = 12'h9C7; nctl = 8'h11; cur_pc = 12'h200;
    step("R12");
    link_we = 0; nctl = 8'hC6; step("R12");
    link_we = 1; bus_val = 12'h333; nctl = 8'h50; cur_pc = 12'h6F0; step("R12");
    link_we = 0; nctl = 8'hC6; step("R12");
    task_id = 4'd11; step("R13");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule